// File: doc/BRIEF.md
# Software-Refilled Translation Lookaside Buffer

This block translates virtual addresses into physical addresses for a processor that sits in front of a physically addressed cache. It is a small, fully associative store of page translations. Each request carries a virtual address, an access kind (read, write or instruction fetch) and a privilege flag. One cycle later the block answers with one of three results: a hit with the physical address, a miss trap, or a protection trap. The page size is 4 KB, so the low 12 bits of the address pass through unchanged and only the page number is looked up.

The block never walks a page table. On a miss it raises a trap and captures the faulting virtual address, and software installs the translation through a write port. That port names an entry slot, a virtual page, a physical page and two rights bits: read-only and kernel-only. Each entry also keeps a reference bit and a dirty bit. These are updated on every accepted access. A victim-hint output tells the refill software which slot to overwrite, so that replacement approximates least-recently-used. An invalidate-all input clears the whole table in one cycle, for example on a context switch.

Top module: `soft_tlb`

## Requirements
- R1: A request with `req_valid` high that matches a valid entry and passes the rights check raises `rsp_hit` for exactly the next cycle. In that cycle `rsp_paddr` is the entry's physical page number followed by request address bits [11:0]. In any cycle after a cycle without a request, `rsp_hit`, `rsp_miss` and `rsp_prot` are all 0, and `rsp_paddr` is 0 whenever `rsp_hit` is 0.
- R2: A request whose page number matches no valid entry raises `rsp_miss` for the next cycle and leaves the table unchanged.
- R3: In the cycle that `rsp_miss` or `rsp_prot` rises, `trap_vaddr` holds the full virtual address of the trapping request. It holds that value until the next trap.
- R4: After reset every entry is invalid, every response output and `trap_vaddr` are 0, and `victim_idx` is 0.
- R5: The access kind is encoded on `req_kind` as 0 for read, 1 for write and 2 for fetch (3 behaves as read). A protection trap occurs on a write to a read-only entry, or on a request with `req_kernel` at 0 to a kernel-only entry. In that case the block raises `rsp_prot` instead of `rsp_hit`, drives `rsp_paddr` to 0, and leaves the entry's reference and dirty bits unchanged.
- R6: An accepted hit sets the entry's reference bit. An accepted write hit also sets its dirty bit. On a hit, `rsp_dirty` reports the entry's dirty bit after that access.
- R7: `victim_idx` is the lowest-numbered entry that is invalid or has its reference bit clear. When every entry is valid and referenced, `victim_idx` is 0 and all reference bits are cleared at the next edge. A hit accepted in that same cycle still sets its own entry's reference bit.
- R8: At most one of `rsp_hit`, `rsp_miss` and `rsp_prot` is high in any cycle.
- R9: A write through the port makes the addressed entry valid with the given fields, and with its reference and dirty bits clear. At the same edge, any other valid entry holding the same virtual page is invalidated. A lookup in the same cycle sees the table as it was before the write.
- R10: `inval_all` makes every entry invalid at the next edge. It takes priority over a port write in the same cycle, which is dropped. A lookup in the same cycle still sees the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A translation request is present this cycle |
| req_vaddr | input | VA_W | Virtual address to translate |
| req_kind | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| req_kernel | input | 1 | 1 when the request is made in kernel mode |
| rsp_hit | output | 1 | Translation succeeded (one cycle after request) |
| rsp_miss | output | 1 | Miss trap: no valid entry for the page |
| rsp_prot | output | 1 | Protection trap: rights check failed |
| rsp_paddr | output | PA_W | Physical address on a hit, else 0 |
| rsp_dirty | output | 1 | Dirty bit of the hit entry after the access |
| trap_vaddr | output | VA_W | Virtual address of the latest trapping request |
| wr_en | input | 1 | Load an entry this cycle |
| wr_index | input | IDX_W | Slot to load |
| wr_vpn | input | VA_W-12 | Virtual page number to load |
| wr_ppn | input | PA_W-12 | Physical page number to load |
| wr_ro | input | 1 | New entry is read-only |
| wr_kern | input | 1 | New entry is kernel-only |
| inval_all | input | 1 | Invalidate every entry |
| victim_idx | output | IDX_W | Suggested slot for the next refill |

## Verification
Several properties are checked on every cycle. The three result flags are never high together, and they stay quiet after an idle cycle. A hit keeps the request's page offset. A trap captures the request address, and `trap_vaddr` is held between traps. A loaded slot becomes valid, `inval_all` empties the table, and the victim hint always points at an invalid or unreferenced slot unless every slot is referenced. The bench's behavioural model covers the rest over directed and random traffic. That includes the physical page returned, when the dirty and reference bits change, and the aging of reference bits when all of them are set. It also covers the removal of duplicate pages on refill, and the ordering of a lookup against a write or invalidate in the same cycle.

// File: rtl/tlb_pkg.sv
// Shared definitions for the translation buffer.
// Assumes: access kind is a 2-bit code; value 3 is treated as a read.
package tlb_pkg;
    localparam int PAGE_BITS = 12;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2
    } acc_kind_t;
endpackage

// File: rtl/tlb_entry_array.sv
// Storage for all translation entries and their per-entry state updates.
// Assumes: at most one entry is flagged in acc_hit (the table keeps pages unique);
// inval_all outranks a port write, a port write outranks access updates.
module tlb_entry_array #(
    parameter int ENTRIES = 128,
    parameter int VPN_W   = 20,
    parameter int PPN_W   = 20,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [ENTRIES-1:0]            acc_hit,
    input  logic                          acc_write,
    input  logic                          age_all,
    input  logic                          wr_en,
    input  logic [IDX_W-1:0]              wr_index,
    input  logic [VPN_W-1:0]              wr_vpn,
    input  logic [PPN_W-1:0]              wr_ppn,
    input  logic                          wr_ro,
    input  logic                          wr_kern,
    input  logic                          inval_all,
    output logic [ENTRIES-1:0]            valid_vec,
    output logic [ENTRIES-1:0][VPN_W-1:0] vpn_tab,
    output logic [ENTRIES-1:0][PPN_W-1:0] ppn_tab,
    output logic [ENTRIES-1:0]            ro_vec,
    output logic [ENTRIES-1:0]            kern_vec,
    output logic [ENTRIES-1:0]            ref_vec,
    output logic [ENTRIES-1:0]            dirty_vec
);

    // Per-entry update of valid, fields, reference and dirty bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_vec <= '0;
            vpn_tab   <= '0;
            ppn_tab   <= '0;
            ro_vec    <= '0;
            kern_vec  <= '0;
            ref_vec   <= '0;
            dirty_vec <= '0;
        end else if (inval_all) begin
            valid_vec <= '0;
        end else begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (wr_en && wr_index == IDX_W'(i)) begin
                    valid_vec[i] <= 1'b1;
                    vpn_tab[i]   <= wr_vpn;
                    ppn_tab[i]   <= wr_ppn;
                    ro_vec[i]    <= wr_ro;
                    kern_vec[i]  <= wr_kern;
                    ref_vec[i]   <= 1'b0;
                    dirty_vec[i] <= 1'b0;
                end else begin
                    if (wr_en && valid_vec[i] && vpn_tab[i] == wr_vpn)
                        valid_vec[i] <= 1'b0;
                    ref_vec[i] <= (ref_vec[i] & ~age_all) | acc_hit[i];
                    if (acc_hit[i] && acc_write)
                        dirty_vec[i] <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/tlb_match.sv
// Fully associative compare of the request page against every entry,
// and one-hot selection of the matching entry's fields.
// Assumes: at most one valid entry holds any page, so an OR of masked fields is exact.
module tlb_match #(
    parameter int ENTRIES = 128,
    parameter int VPN_W   = 20,
    parameter int PPN_W   = 20
) (
    input  logic [VPN_W-1:0]              req_vpn,
    input  logic [ENTRIES-1:0]            valid_vec,
    input  logic [ENTRIES-1:0][VPN_W-1:0] vpn_tab,
    input  logic [ENTRIES-1:0][PPN_W-1:0] ppn_tab,
    input  logic [ENTRIES-1:0]            ro_vec,
    input  logic [ENTRIES-1:0]            kern_vec,
    input  logic [ENTRIES-1:0]            dirty_vec,
    output logic [ENTRIES-1:0]            match_vec,
    output logic                          hit_any,
    output logic [PPN_W-1:0]              sel_ppn,
    output logic                          sel_ro,
    output logic                          sel_kern,
    output logic                          sel_dirty
);

    // One comparator per entry.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match_vec[g] = valid_vec[g] && (vpn_tab[g] == req_vpn);
    end

    assign hit_any = |match_vec;

    // Masked OR of the fields of the single matching entry.
    always_comb begin
        sel_ppn   = '0;
        sel_ro    = 1'b0;
        sel_kern  = 1'b0;
        sel_dirty = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match_vec[i]) begin
                sel_ppn   = sel_ppn | ppn_tab[i];
                sel_ro    = sel_ro | ro_vec[i];
                sel_kern  = sel_kern | kern_vec[i];
                sel_dirty = sel_dirty | dirty_vec[i];
            end
        end
    end

endmodule

// File: rtl/tlb_victim.sv
// Replacement hint: lowest slot that is free or unreferenced; flags when
// every slot is valid and referenced so the reference bits can be aged.
module tlb_victim #(
    parameter int ENTRIES = 128,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0] valid_vec,
    input  logic [ENTRIES-1:0] ref_vec,
    output logic [IDX_W-1:0]   victim_idx,
    output logic               age_all
);

    logic [ENTRIES-1:0] cand;

    assign cand    = ~valid_vec | ~ref_vec;
    assign age_all = ~|cand;

    // Priority pick of the lowest candidate index.
    always_comb begin
        victim_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (cand[i])
                victim_idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/soft_tlb.sv
// Top level: fully associative translation buffer refilled by software.
// Lookup is combinational on the current table; the response is registered
// one cycle after the request. Misses and rights violations trap and latch
// the faulting address. Assumes 4 KB pages and ENTRIES >= 2.
module soft_tlb #(
    parameter int ENTRIES = 128,
    parameter int VA_W    = 32,
    parameter int PA_W    = 32,
    localparam int OFF_W  = tlb_pkg::PAGE_BITS,
    localparam int VPN_W  = VA_W - OFF_W,
    localparam int PPN_W  = PA_W - OFF_W,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic [1:0]       req_kind,
    input  logic             req_kernel,
    output logic             rsp_hit,
    output logic             rsp_miss,
    output logic             rsp_prot,
    output logic [PA_W-1:0]  rsp_paddr,
    output logic             rsp_dirty,
    output logic [VA_W-1:0]  trap_vaddr,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_index,
    input  logic [VPN_W-1:0] wr_vpn,
    input  logic [PPN_W-1:0] wr_ppn,
    input  logic             wr_ro,
    input  logic             wr_kern,
    input  logic             inval_all,
    output logic [IDX_W-1:0] victim_idx
);
    import tlb_pkg::*;

    logic [ENTRIES-1:0]            valid_vec, ro_vec, kern_vec, ref_vec, dirty_vec;
    logic [ENTRIES-1:0][VPN_W-1:0] vpn_tab;
    logic [ENTRIES-1:0][PPN_W-1:0] ppn_tab;
    logic [ENTRIES-1:0]            match_vec, acc_hit;
    logic                          hit_any, sel_ro, sel_kern, sel_dirty;
    logic [PPN_W-1:0]              sel_ppn;
    logic                          age_all, is_write, prot_fail, accept;

    assign is_write  = (acc_kind_t'(req_kind) == ACC_WRITE);
    assign prot_fail = hit_any && ((is_write && sel_ro) || (!req_kernel && sel_kern));
    assign accept    = req_valid && hit_any && !prot_fail;
    assign acc_hit   = accept ? match_vec : '0;

    tlb_entry_array #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_hit   (acc_hit),
        .acc_write (is_write),
        .age_all   (age_all),
        .wr_en     (wr_en),
        .wr_index  (wr_index),
        .wr_vpn    (wr_vpn),
        .wr_ppn    (wr_ppn),
        .wr_ro     (wr_ro),
        .wr_kern   (wr_kern),
        .inval_all (inval_all),
        .valid_vec (valid_vec),
        .vpn_tab   (vpn_tab),
        .ppn_tab   (ppn_tab),
        .ro_vec    (ro_vec),
        .kern_vec  (kern_vec),
        .ref_vec   (ref_vec),
        .dirty_vec (dirty_vec)
    );

    tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_match (
        .req_vpn   (req_vaddr[VA_W-1:OFF_W]),
        .valid_vec (valid_vec),
        .vpn_tab   (vpn_tab),
        .ppn_tab   (ppn_tab),
        .ro_vec    (ro_vec),
        .kern_vec  (kern_vec),
        .dirty_vec (dirty_vec),
        .match_vec (match_vec),
        .hit_any   (hit_any),
        .sel_ppn   (sel_ppn),
        .sel_ro    (sel_ro),
        .sel_kern  (sel_kern),
        .sel_dirty (sel_dirty)
    );

    tlb_victim #(.ENTRIES(ENTRIES)) u_victim (
        .valid_vec  (valid_vec),
        .ref_vec    (ref_vec),
        .victim_idx (victim_idx),
        .age_all    (age_all)
    );

    // Registered response flags, physical address and dirty report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_hit   <= 1'b0;
            rsp_miss  <= 1'b0;
            rsp_prot  <= 1'b0;
            rsp_paddr <= '0;
            rsp_dirty <= 1'b0;
        end else begin
            rsp_hit   <= accept;
            rsp_miss  <= req_valid && !hit_any;
            rsp_prot  <= req_valid && prot_fail;
            rsp_paddr <= accept ? {sel_ppn, req_vaddr[OFF_W-1:0]} : '0;
            rsp_dirty <= accept && (sel_dirty || is_write);
        end
    end

    // Capture of the faulting address on either kind of trap.
    always_ff @(posedge clk) begin
        if (!rst_n)
            trap_vaddr <= '0;
        else if (req_valid && (!hit_any || prot_fail))
            trap_vaddr <= req_vaddr;
    end

endmodule

// File: rtl/soft_tlb_checker.sv
// Cycle-by-cycle properties of the translation buffer, bound to soft_tlb.
module soft_tlb_checker #(
    parameter int ENTRIES = 128,
    parameter int VA_W    = 32,
    parameter int PA_W    = 32,
    parameter int IDX_W   = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [VA_W-1:0]  req_vaddr,
    input logic             rsp_hit,
    input logic             rsp_miss,
    input logic             rsp_prot,
    input logic [PA_W-1:0]  rsp_paddr,
    input logic [VA_W-1:0]  trap_vaddr,
    input logic             wr_en,
    input logic [IDX_W-1:0] wr_index,
    input logic             inval_all,
    input logic [IDX_W-1:0] victim_idx,
    input logic [ENTRIES-1:0] valid_vec,
    input logic [ENTRIES-1:0] ref_vec
);

    // R8
    flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rsp_hit, rsp_miss, rsp_prot}));

    // R1
    quiet_after_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !(rsp_hit || rsp_miss || rsp_prot));

    // R1
    offset_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> rsp_paddr[11:0] == $past(req_vaddr[11:0]));

    // R3
    trap_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_miss || rsp_prot) |-> trap_vaddr == $past(req_vaddr));

    // R3
    trap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_miss || rsp_prot) |-> $stable(trap_vaddr));

    // R9
    load_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !inval_all) |=> valid_vec[$past(wr_index)]);

    // R10
    flush_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inval_all |=> valid_vec == '0);

    // R7
    victim_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid_vec[victim_idx] && ref_vec[victim_idx]) || (&(valid_vec & ref_vec)));

endmodule

bind soft_tlb soft_tlb_checker #(
    .ENTRIES (ENTRIES),
    .VA_W    (VA_W),
    .PA_W    (PA_W),
    .IDX_W   (IDX_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_vaddr  (req_vaddr),
    .rsp_hit    (rsp_hit),
    .rsp_miss   (rsp_miss),
    .rsp_prot   (rsp_prot),
    .rsp_paddr  (rsp_paddr),
    .trap_vaddr (trap_vaddr),
    .wr_en      (wr_en),
    .wr_index   (wr_index),
    .inval_all  (inval_all),
    .victim_idx (victim_idx),
    .valid_vec  (valid_vec),
    .ref_vec    (ref_vec)
);

// File: tb/soft_tlb_test.sv
`timescale 1ns/1ps
module soft_tlb_test;
    localparam int N     = 8;
    localparam int VA_W  = 32;
    localparam int PA_W  = 32;
    localparam int IDX_W = $clog2(N);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic [VA_W-1:0]  req_vaddr = '0;
    logic [1:0]       req_kind = 2'd0;
    logic             req_kernel = 1'b0;
    logic             rsp_hit, rsp_miss, rsp_prot, rsp_dirty;
    logic [PA_W-1:0]  rsp_paddr;
    logic [VA_W-1:0]  trap_vaddr;
    logic             wr_en = 1'b0;
    logic [IDX_W-1:0] wr_index = '0;
    logic [19:0]      wr_vpn = '0;
    logic [19:0]      wr_ppn = '0;
    logic             wr_ro = 1'b0, wr_kern = 1'b0, inval_all = 1'b0;
    logic [IDX_W-1:0] victim_idx;

    int checks = 0, fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    soft_tlb #(.ENTRIES(N), .VA_W(VA_W), .PA_W(PA_W)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_kind(req_kind), .req_kernel(req_kernel), .rsp_hit(rsp_hit),
        .rsp_miss(rsp_miss), .rsp_prot(rsp_prot), .rsp_paddr(rsp_paddr),
        .rsp_dirty(rsp_dirty), .trap_vaddr(trap_vaddr), .wr_en(wr_en),
        .wr_index(wr_index), .wr_vpn(wr_vpn), .wr_ppn(wr_ppn), .wr_ro(wr_ro),
        .wr_kern(wr_kern), .inval_all(inval_all), .victim_idx(victim_idx)
    );

    // Behavioural reference model
    bit           m_val[N], m_ro[N], m_kern[N], m_ref[N], m_dirty[N];
    int unsigned  m_vpn[N], m_ppn[N];
    bit           e_hit, e_miss, e_prot, e_dirty;
    logic [31:0]  e_paddr, e_trap;

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_val[i]) begin
                m_val[i] = 0; m_ref[i] = 0; m_dirty[i] = 0;
            end
            e_hit = 0; e_miss = 0; e_prot = 0; e_dirty = 0;
            e_paddr = 0; e_trap = 0;
        end else begin
            int  idx;
            bit  found, bad, wr_acc, aging;
            idx = -1;
            found = 0;
            for (int i = 0; i < N; i++)
                if (m_val[i] && m_vpn[i] == int'(req_vaddr[31:12])) begin
                    found = 1; idx = i;
                end
            wr_acc = (req_kind == 2'd1);
            bad = found && ((wr_acc && m_ro[idx]) || (!req_kernel && m_kern[idx]));
            e_hit  = req_valid && found && !bad;
            e_miss = req_valid && !found;
            e_prot = req_valid && bad;
            e_paddr = e_hit ? {m_ppn[idx][19:0], req_vaddr[11:0]} : 32'd0;
            e_dirty = e_hit && (m_dirty[idx] || wr_acc);
            if (e_miss || e_prot) e_trap = req_vaddr;
            aging = 1;
            for (int i = 0; i < N; i++)
                if (!m_val[i] || !m_ref[i]) aging = 0;
            if (inval_all) begin
                foreach (m_val[i]) m_val[i] = 0;
            end else begin
                for (int i = 0; i < N; i++) begin
                    if (wr_en && int'(wr_index) == i) begin
                        m_val[i] = 1; m_vpn[i] = wr_vpn; m_ppn[i] = wr_ppn;
                        m_ro[i] = wr_ro; m_kern[i] = wr_kern;
                        m_ref[i] = 0; m_dirty[i] = 0;
                    end else begin
                        if (wr_en && m_val[i] && m_vpn[i] == int'(wr_vpn)) m_val[i] = 0;
                        if (aging) m_ref[i] = 0;
                        if (e_hit && i == idx) begin
                            m_ref[i] = 1;
                            if (wr_acc) m_dirty[i] = 1;
                        end
                    end
                end
            end
        end
    end

    function automatic int exp_victim();
        for (int i = 0; i < N; i++)
            if (!m_val[i] || !m_ref[i]) return i;
        return 0;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R1 hit", 32'(rsp_hit), 32'(e_hit));
            chk("R1 paddr", rsp_paddr, e_paddr);
            chk("R2 miss", 32'(rsp_miss), 32'(e_miss));
            chk("R3 trap_vaddr", trap_vaddr, e_trap);
            chk("R5 prot", 32'(rsp_prot), 32'(e_prot));
            chk("R6 dirty", 32'(rsp_dirty), 32'(e_dirty));
            chk("R7 victim", 32'(victim_idx), 32'(exp_victim()));
            chk("R8 onehot", 32'($countones({rsp_hit, rsp_miss, rsp_prot}) <= 1), 32'd1);
        end
    end

    task automatic idle();
        @(negedge clk);
        req_valid = 0; wr_en = 0; inval_all = 0;
    endtask

    task automatic req(logic [31:0] va, logic [1:0] kind, bit kern);
        @(negedge clk);
        wr_en = 0; inval_all = 0;
        req_valid = 1; req_vaddr = va; req_kind = kind; req_kernel = kern;
    endtask

    task automatic load(int idx, int vpn, int ppn, bit ro, bit kern);
        @(negedge clk);
        req_valid = 0; inval_all = 0;
        wr_en = 1; wr_index = IDX_W'(idx); wr_vpn = 20'(vpn); wr_ppn = 20'(ppn);
        wr_ro = ro; wr_kern = kern;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            done = 1;
            fails++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R4 reset state
        chk("R4 hit", 32'(rsp_hit), 0);
        chk("R4 trap", trap_vaddr, 0);
        chk("R4 victim", 32'(victim_idx), 0);

        // R2 miss on an empty table
        req(32'h1234_5678, 2'd0, 0);
        idle();
        chk("R2 directed miss", 32'(rsp_miss), 1);
        chk("R3 directed trap", trap_vaddr, 32'h1234_5678);

        // R1 hit with offset kept
        load(0, 32'h12345, 32'h00ABC, 0, 0);
        req(32'h1234_5678, 2'd0, 0);
        idle();
        chk("R1 directed paddr", rsp_paddr, 32'h00AB_C678);
        chk("R7 victim after ref", 32'(victim_idx), 1);

        // R6 write hit marks dirty
        req(32'h1234_5000, 2'd1, 0);
        idle();
        chk("R6 directed dirty", 32'(rsp_dirty), 1);

        // R5 write to read-only, user access to kernel-only
        load(1, 32'h00077, 32'h00011, 1, 0);
        load(2, 32'h00088, 32'h00022, 0, 1);
        req(32'h0007_7004, 2'd1, 1);
        idle();
        chk("R5 ro write", 32'(rsp_prot), 1);
        req(32'h0008_8004, 2'd2, 0);
        idle();
        chk("R5 user to kernel", 32'(rsp_prot), 1);
        req(32'h0008_8004, 2'd2, 1);
        idle();
        chk("R5 kernel fetch ok", 32'(rsp_hit), 1);

        // R9 duplicate page replaces the older slot
        load(5, 32'h12345, 32'h00DEF, 0, 0);
        req(32'h1234_5001, 2'd0, 0);
        idle();
        chk("R9 new ppn", rsp_paddr, 32'h00DE_F001);
        chk("R9 fresh dirty clear", 32'(rsp_dirty), 0);

        // R10 invalidate beats write in the same cycle
        @(negedge clk);
        req_valid = 0; wr_en = 1; wr_index = 3; wr_vpn = 20'h00099; inval_all = 1;
        req(32'h0009_9000, 2'd0, 1);
        idle();
        chk("R10 flushed", 32'(rsp_miss), 1);

        // R7 aging: fill and reference every slot
        for (int i = 0; i < N; i++) load(i, 32'h100 + i, 32'h200 + i, 0, 0);
        for (int i = 0; i < N; i++) req(32'((32'h100 + i) << 12), 2'd0, 0);
        idle();
        chk("R7 all referenced", 32'(victim_idx), 0);
        idle();
        chk("R7 after aging", 32'(victim_idx), 0);

        // Random traffic compared against the model each cycle
        for (int n = 0; n < 4000; n++) begin
            int r;
            r = $urandom_range(0, 99);
            if (r < 60)
                req({12'h000, 8'($urandom_range(0, 11)), 12'($urandom)},
                    2'($urandom_range(0, 3)), 1'($urandom));
            else if (r < 97) begin
                @(negedge clk);
                req_valid = 1'($urandom); req_vaddr = {12'h000, 8'($urandom_range(0, 11)), 12'($urandom)};
                req_kind = 2'($urandom); req_kernel = 1'($urandom);
                wr_en = 1; wr_index = IDX_W'($urandom); wr_vpn = 20'($urandom_range(0, 11));
                wr_ppn = 20'($urandom); wr_ro = 1'($urandom); wr_kern = 1'($urandom);
                inval_all = 0;
            end else begin
                @(negedge clk);
                req_valid = 1'($urandom); wr_en = 1'($urandom); inval_all = 1;
            end
        end
        idle();
        idle();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule